// File: doc/BRIEF.md
# Configurable Output Macrocell for a Small PLD

This block is one output cell of a small programmable logic device. It sits between the product-term array and one tri-state pad. The array supplies a sum term for the cell's logic, a product term of its own for output enable, and two terms shared by all cells: one that clears the register at once and one that sets it on the next clock edge. A two-bit configuration chooses whether the pad follows a D flip-flop or the sum term directly, and whether the pad shows the true or the inverted value.

The cell sends a feedback signal back to the array in both polarities. In registered mode the feedback comes from the register, so the pad cannot act as an input. In combinatorial mode the feedback comes from the pad level, so a value driven from outside is seen whenever the cell's own driver is off. For testing state machines, a preload path loads any chosen value into the register on a clock edge. A power-on clear leaves the register at zero, so the pad level after power-up depends on the programmed polarity.

Top module: `pld_out_cell`

## Requirements
- R1: While `rst_n` is low the register holds 0. The pad then reads 0 in registered active-high mode and 1 in registered active-low mode.
- R2: In registered mode the register takes `sum_term` on each rising clock edge when no clear, preset or preload is active. `pad_out` shows the register value, inverted when the polarity bit is 0.
- R3: In combinatorial mode `pad_out` follows `sum_term` with no clock edge needed. It is inverted when the polarity bit is 0.
- R4: `pad_oe` equals `oe_term` in every mode.
- R5: In registered mode `fb_true` equals the register value, whatever level `pad_in` has.
- R6: In combinatorial mode `fb_true` is the pad level. That is `pad_out` while `oe_term` is 1 and `pad_in` while `oe_term` is 0.
- R7: `fb_comp` is always the inverse of `fb_true`.
- R8: `ar_term` = 1 clears the register to 0 at once, with no clock edge. The clear acts on the register value, so an active-low pad then reads 1.
- R9: `sp_term` = 1 sets the register to 1 on the next rising edge, not before. It takes priority over the sum term.
- R10: `pl_en` = 1 loads `pl_val` into the register on the next rising edge. It takes priority over both the preset and the sum term.
- R11: `ar_term` takes priority over preset and preload. While it is 1 the register stays 0 across clock edges.
- R12: Configuration encoding: `cfg[1]` = 1 selects registered mode and 0 selects combinatorial mode. `cfg[0]` = 1 selects an active-high pad and 0 selects an active-low pad.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Power-on clear, active low, asynchronous |
| cfg | input | 2 | Bit 1 selects the mode, bit 0 selects the polarity |
| sum_term | input | 1 | Sum of products from the array |
| oe_term | input | 1 | Output-enable product term |
| ar_term | input | 1 | Shared asynchronous clear term |
| sp_term | input | 1 | Shared synchronous preset term |
| pl_en | input | 1 | Test preload strobe |
| pl_val | input | 1 | Value loaded by the preload |
| pad_in | input | 1 | Level on the pad from outside |
| pad_out | output | 1 | Value driven toward the pad |
| pad_oe | output | 1 | Pad driver enable |
| fb_true | output | 1 | Feedback to the array, true form |
| fb_comp | output | 1 | Feedback to the array, complement form |

## Verification
The hardest cases to reach are the ones where the register value and the pad level disagree. Two examples: an active-low registered pad that reads high right after an asynchronous clear, and a preload that has to win over a preset asserted in the same cycle. The stimulus first drives the register to 1 through ordinary capture. It then raises the clear between clock edges and checks the pad before any edge arrives. Next it holds the clear together with preset and preload across an edge, and finally releases the clear to show that the preset acts only on the edge after that.

// File: rtl/pld_cell_pkg.sv
package pld_cell_pkg;

   localparam int CELL_CFG_W = 2;
   localparam int CFG_MODE_BIT = 1;
   localparam int CFG_POL_BIT = 0;

   typedef enum logic [1:0] {
      CELL_COMB_LOW  = 2'b00,
      CELL_COMB_HIGH = 2'b01,
      CELL_REG_LOW   = 2'b10,
      CELL_REG_HIGH  = 2'b11
   } cell_mode_e;

   typedef struct packed {
      logic registered;
      logic active_high;
   } cell_sel_t;

   function automatic cell_sel_t cell_decode(input logic [CELL_CFG_W-1:0] c);
      cell_sel_t s;
      s.registered  = c[CFG_MODE_BIT];
      s.active_high = c[CFG_POL_BIT];
      return s;
   endfunction

endpackage

// File: rtl/cell_cfg_decode.sv
module cell_cfg_decode
   import pld_cell_pkg::*;
#(
   parameter int CFG_W = CELL_CFG_W
)(
   input  logic [CFG_W-1:0] cfg,
   output cell_sel_t        sel
);
   if (CFG_W != CELL_CFG_W) begin : g_bad_width
      $error("cell_cfg_decode: CFG_W must be %0d", CELL_CFG_W);
   end

   cell_mode_e mode;
   always_comb begin
      mode = cell_mode_e'(cfg[1:0]);
      sel  = cell_decode(mode);
   end
endmodule

// File: rtl/cell_flop.sv
module cell_flop #(
   parameter bit PRELOAD_EN = 1'b1
)(
   input  logic clk,
   input  logic clr,
   input  logic sp,
   input  logic pl_en,
   input  logic pl_val,
   input  logic d,
   output logic q
);
   logic d_next;

   if (PRELOAD_EN) begin : g_preload
      always_comb begin
         if (pl_en)   d_next = pl_val;
         else if (sp) d_next = 1'b1;
         else         d_next = d;
      end
   end else begin : g_no_preload
      logic unused_pl;
      assign unused_pl = pl_en ^ pl_val;
      always_comb d_next = sp ? 1'b1 : d;
   end

   always_ff @(posedge clk or posedge clr) begin
      if (clr) q <= 1'b0;
      else     q <= d_next;
   end
endmodule

// File: rtl/cell_io_stage.sv
module cell_io_stage
   import pld_cell_pkg::*;
(
   input  cell_sel_t sel,
   input  logic      q,
   input  logic      sum_term,
   input  logic      oe_term,
   input  logic      pad_in,
   output logic      pad_out,
   output logic      pad_oe,
   output logic      fb_true,
   output logic      fb_comp
);
   logic core_val;
   logic pin_level;
   logic q_n;

   always_comb begin
      q_n       = ~q;
      core_val  = sel.registered ? q : sum_term;
      pad_out   = sel.active_high ? core_val : ~core_val;
      pad_oe    = oe_term;
      pin_level = oe_term ? pad_out : pad_in;
      // registered feedback is taken from the inverted register node
      fb_comp   = sel.registered ? q_n : ~pin_level;
      fb_true   = ~fb_comp;
   end
endmodule

// File: rtl/pld_out_cell.sv
module pld_out_cell
   import pld_cell_pkg::*;
#(
   parameter int CFG_W      = CELL_CFG_W,
   parameter bit PRELOAD_EN = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CFG_W-1:0] cfg,
   input  logic             sum_term,
   input  logic             oe_term,
   input  logic             ar_term,
   input  logic             sp_term,
   input  logic             pl_en,
   input  logic             pl_val,
   input  logic             pad_in,
   output logic             pad_out,
   output logic             pad_oe,
   output logic             fb_true,
   output logic             fb_comp
);
   cell_sel_t sel;
   logic      clr_any;
   logic      reg_q;

   assign clr_any = ar_term | ~rst_n;

   cell_cfg_decode #(.CFG_W(CFG_W)) i_dec (
      .cfg (cfg),
      .sel (sel)
   );

   cell_flop #(.PRELOAD_EN(PRELOAD_EN)) i_flop (
      .clk    (clk),
      .clr    (clr_any),
      .sp     (sp_term),
      .pl_en  (pl_en),
      .pl_val (pl_val),
      .d      (sum_term),
      .q      (reg_q)
   );

   cell_io_stage i_io (
      .sel      (sel),
      .q        (reg_q),
      .sum_term (sum_term),
      .oe_term  (oe_term),
      .pad_in   (pad_in),
      .pad_out  (pad_out),
      .pad_oe   (pad_oe),
      .fb_true  (fb_true),
      .fb_comp  (fb_comp)
   );
endmodule

// File: rtl/pld_out_cell_chk.sv
module pld_out_cell_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] cfg,
   input logic       sum_term,
   input logic       ar_term,
   input logic       sp_term,
   input logic       pl_en,
   input logic       pl_val,
   input logic       fb_true,
   input logic       reg_q
);
   assert_clear_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ar_term |-> !reg_q);

   assert_preset_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_term && !ar_term && !pl_en) |=> (ar_term || reg_q));

   assert_preload_loads_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pl_en && !ar_term) |=> (ar_term || reg_q == $past(pl_val)));

   assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ar_term && !sp_term && !pl_en) |=> (ar_term || reg_q == $past(sum_term)));

   assert_reg_feedback_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cfg[1] |-> (fb_true == reg_q));
endmodule

bind pld_out_cell pld_out_cell_chk i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg      (cfg[1:0]),
   .sum_term (sum_term),
   .ar_term  (ar_term),
   .sp_term  (sp_term),
   .pl_en    (pl_en),
   .pl_val   (pl_val),
   .fb_true  (fb_true),
   .reg_q    (reg_q)
);

// File: tb/test_pld_out_cell.sv
module test_pld_out_cell;
   logic clk = 1'b0;
   logic rst_n, sum_term, oe_term, ar_term, sp_term, pl_en, pl_val, pad_in;
   logic [1:0] cfg;
   logic pad_out, pad_oe, fb_true, fb_comp;
   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pld_out_cell i_pld_out_cell (
      .clk(clk), .rst_n(rst_n), .cfg(cfg), .sum_term(sum_term),
      .oe_term(oe_term), .ar_term(ar_term), .sp_term(sp_term),
      .pl_en(pl_en), .pl_val(pl_val), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .fb_true(fb_true), .fb_comp(fb_comp)
   );

   // {cfg[1:0], sum, oe, pin, pl_en, pl_val, sp, exp_out, exp_oe, exp_fbt, exp_fbc}
   localparam int NV = 11;
   localparam logic [11:0] VEC [NV] = '{
      12'b11_1_1_0_0_0_0_1_1_1_0,
      12'b11_0_0_1_0_0_0_0_0_0_1,
      12'b10_1_1_0_0_0_0_0_1_1_0,
      12'b10_0_1_0_0_0_1_0_1_1_0,
      12'b11_1_1_0_1_0_1_0_1_0_1,
      12'b11_0_1_0_1_1_0_1_1_1_0,
      12'b01_1_1_0_0_0_0_1_1_1_0,
      12'b01_1_0_0_0_0_0_1_0_0_1,
      12'b00_1_1_1_0_0_0_0_1_0_1,
      12'b00_0_0_1_0_0_0_1_0_1_0,
      12'b00_0_1_0_0_0_0_1_1_1_0
   };

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      rst_n = 1'b0; cfg = 2'b11; sum_term = 1'b0; oe_term = 1'b1; ar_term = 1'b0;
      sp_term = 1'b0; pl_en = 1'b0; pl_val = 1'b0; pad_in = 1'b0;
      repeat (2) @(posedge clk);
      #2;
      check("R1 reset active-high pad", pad_out, 1'b0);
      cfg = 2'b10; #1;
      check("R1 reset active-low pad", pad_out, 1'b1);
      check("R12 registered low feedback", fb_true, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;

      // vector table: R2 R3 R4 R5 R6 R7 R9 R10 R12
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         {cfg, sum_term, oe_term, pad_in, pl_en, pl_val, sp_term} = VEC[i][11:4];
         @(posedge clk);
         #2;
         check($sformatf("R2 R3 R12 pad_out vec %0d", i), pad_out, VEC[i][3]);
         check($sformatf("R4 pad_oe vec %0d", i), pad_oe, VEC[i][2]);
         check($sformatf("R5 R6 fb_true vec %0d", i), fb_true, VEC[i][1]);
         check($sformatf("R7 fb_comp vec %0d", i), fb_comp, VEC[i][0]);
      end

      // R3: combinatorial path reacts between edges
      @(negedge clk);
      cfg = 2'b01; sum_term = 1'b0; oe_term = 1'b1; #1;
      check("R3 comb no clock low", pad_out, 1'b0);
      sum_term = 1'b1; #1;
      check("R3 comb no clock high", pad_out, 1'b1);

      // R8: register at 1, clear between edges
      @(negedge clk);
      cfg = 2'b11; sum_term = 1'b1;
      @(posedge clk); #2;
      check("R2 register holds one", pad_out, 1'b1);
      ar_term = 1'b1; #1;
      check("R8 clear without clock", pad_out, 1'b0);
      cfg = 2'b10; #1;
      check("R8 cleared active-low pad high", pad_out, 1'b1);

      // R11: clear held with preset and preload across an edge
      @(negedge clk);
      cfg = 2'b11; sp_term = 1'b1; pl_en = 1'b1; pl_val = 1'b1;
      @(posedge clk); #2;
      check("R11 clear beats preset and preload", pad_out, 1'b0);

      // R9: preset acts only on the edge
      @(negedge clk);
      ar_term = 1'b0; pl_en = 1'b0; sum_term = 1'b0; sp_term = 1'b1; #1;
      check("R9 preset waits for edge", pad_out, 1'b0);
      @(posedge clk); #2;
      check("R9 preset sets on edge", pad_out, 1'b1);
      @(negedge clk);
      sp_term = 1'b0;
      @(posedge clk); #2;
      check("R2 capture after preset", pad_out, 1'b0);

      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule